// File: doc/BRIEF.md
# Accumulator Register-Operation Unit

This unit carries out the register-operation group of a 16-bit accumulator machine. It runs only after the surrounding control has found an instruction with opcode 7 and the indirect bit clear. It receives the low 12 bits of that instruction word as an operation field, together with a one-cycle execute strobe. It holds the accumulator and the one-bit extension flag E. It returns a skip request to the program counter logic and a sticky halt flag. It has no part in memory access, the bus or instruction fetch.

Each operation is selected by one bit of the field. The operations clear or complement either register, rotate the 17-bit ring formed by the accumulator and E, increment the accumulator, test a condition for a skip, or halt the machine. The unit acts only on a strobe whose field has exactly one bit set. All results are registered and appear in the cycle after the strobe edge.

Top module: `acc_regop_unit`

## Requirements
- R1: After reset (rst_n low), acc_out is 0000h, ext_out is 0, skip_pulse is 0 and halted is 0.
- R2: A strobe with field bit 11 set (field 800h) clears the accumulator and leaves E unchanged. A strobe with field bit 10 set (400h) clears E and leaves the accumulator unchanged.
- R3: Field bit 9 (200h) replaces the accumulator with its bitwise complement. Field bit 8 (100h) inverts E. Neither operation changes the other register.
- R4: Field bit 7 (080h) rotates right by one place through E: E goes to accumulator bit 15, accumulator bits 15..1 move down one place, and accumulator bit 0 goes to E.
- R5: Field bit 6 (040h) rotates left by one place through E: E goes to accumulator bit 0, accumulator bits 14..0 move up one place, and accumulator bit 15 goes to E.
- R6: Field bit 5 (020h) adds one to the accumulator, wrapping from FFFFh to 0000h. E is unchanged.
- R7: The skip tests leave the accumulator and E unchanged. Each one raises skip_pulse in the cycle after the strobe only when its condition holds. The tests are: bit 4 (010h), accumulator bit 15 is 0; bit 3 (008h), accumulator bit 15 is 1; bit 2 (004h), accumulator is zero; bit 1 (002h), E is 0.
- R8: Field bit 0 (001h) sets halted. Halted stays set until reset. While halted is set, strobes change neither register and raise no skip.
- R9: A strobe whose field has no bit set or more than one bit set has no effect. A field presented while exec_en is low has no effect.
- R10: skip_pulse is high for exactly one cycle per qualifying skip strobe. It is low in the cycle after that if no new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_en | input | 1 | Execute strobe for the present field |
| op_field | input | 12 | Operation field, one bit per operation |
| acc_out | output | 16 | Accumulator |
| ext_out | output | 1 | Extension flag E |
| skip_pulse | output | 1 | Request to skip the next instruction |
| halted | output | 1 | Machine halted, sticky until reset |

## Verification
The accumulator is built up bit by bit through the interface, using left rotates fed from E. The rotates are run on values with set end bits, such as 8001h, so that a wrong direction or a lost E bit gives a different result. The increment is tried at FFFFh and at 7FFFh, which separates a correct wrap from a sign-bit error. Each skip test is run on zero, negative and small positive accumulator values and with both E states, so every condition is seen both true and false. Fields with no bit set or two bits set, a strobe held low, and strobes after a halt all have to leave the outputs unchanged.

// File: rtl/regop_pkg.sv
// Package: field bit positions and widths shared by the register-operation unit.
// Assumes the field layout is fixed by the instruction encoding.
package regop_pkg;
    localparam int unsigned FIELD_W  = 12;
    localparam int unsigned B_CLR_A  = 11;
    localparam int unsigned B_CLR_E  = 10;
    localparam int unsigned B_CPL_A  = 9;
    localparam int unsigned B_CPL_E  = 8;
    localparam int unsigned B_ROT_R  = 7;
    localparam int unsigned B_ROT_L  = 6;
    localparam int unsigned B_INC_A  = 5;
    localparam int unsigned B_SK_POS = 4;
    localparam int unsigned B_SK_NEG = 3;
    localparam int unsigned B_SK_ZA  = 2;
    localparam int unsigned B_SK_ZE  = 1;
    localparam int unsigned B_HALT   = 0;
endpackage

// File: rtl/regop_alu.sv
// Module: regop_alu
// Computes the next accumulator and E values for one operation field.
// Assumes the field has exactly one bit set; skip and halt bits leave both registers as they are.
module regop_alu
    import regop_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [FIELD_W-1:0] op,
    input  logic [DATA_W-1:0]  acc,
    input  logic               ext,
    output logic [DATA_W-1:0]  acc_nx,
    output logic               ext_nx
);
    localparam int unsigned MSB = DATA_W - 1;

    // Select the result of the one operation that the field names.
    always_comb begin
        acc_nx = acc;
        ext_nx = ext;
        if (op[B_CLR_A]) begin
            acc_nx = '0;
        end else if (op[B_CLR_E]) begin
            ext_nx = 1'b0;
        end else if (op[B_CPL_A]) begin
            acc_nx = ~acc;
        end else if (op[B_CPL_E]) begin
            ext_nx = ~ext;
        end else if (op[B_ROT_R]) begin
            acc_nx = {ext, acc[MSB:1]};
            ext_nx = acc[0];
        end else if (op[B_ROT_L]) begin
            acc_nx = {acc[MSB-1:0], ext};
            ext_nx = acc[MSB];
        end else if (op[B_INC_A]) begin
            acc_nx = acc + 1'b1;
        end
    end
endmodule

// File: rtl/regop_skip.sv
// Module: regop_skip
// Evaluates the skip test that the field selects against the present accumulator and E.
// Assumes at most one skip bit is set; yields 0 for fields that select no skip test.
module regop_skip
    import regop_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [FIELD_W-1:0] op,
    input  logic [DATA_W-1:0]  acc,
    input  logic               ext,
    output logic               take
);
    localparam int unsigned MSB = DATA_W - 1;

    logic sign_bit;
    logic acc_zero;

    // Form the two accumulator status terms used by the tests.
    always_comb begin
        sign_bit = acc[MSB];
        acc_zero = (acc == '0);
    end

    // OR together the selected tests whose condition holds.
    always_comb begin
        take = (op[B_SK_POS] & ~sign_bit)
             | (op[B_SK_NEG] &  sign_bit)
             | (op[B_SK_ZA]  &  acc_zero)
             | (op[B_SK_ZE]  & ~ext);
    end
endmodule

// File: rtl/acc_regop_unit.sv
// Module: acc_regop_unit
// Executes register-operation instructions on the accumulator and E flag.
// Assumes the caller strobes exec_en for one cycle per decoded instruction.
// Fields that are not one-hot are ignored, and strobes are ignored once halted.
module acc_regop_unit
    import regop_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec_en,
    input  logic [11:0]        op_field,
    output logic [DATA_W-1:0]  acc_out,
    output logic               ext_out,
    output logic               skip_pulse,
    output logic               halted
);
    logic [DATA_W-1:0] acc_q, acc_nx;
    logic              ext_q, ext_nx;
    logic              skip_q, halt_q;
    logic              take;
    logic              one_hot;
    logic              fire;

    regop_alu #(.DATA_W(DATA_W)) i_alu (
        .op     (op_field),
        .acc    (acc_q),
        .ext    (ext_q),
        .acc_nx (acc_nx),
        .ext_nx (ext_nx)
    );

    regop_skip #(.DATA_W(DATA_W)) i_skip (
        .op   (op_field),
        .acc  (acc_q),
        .ext  (ext_q),
        .take (take)
    );

    // Qualify the strobe: one bit set and the machine not halted.
    always_comb begin
        one_hot = (op_field != '0) && ((op_field & (op_field - 1'b1)) == '0);
        fire    = exec_en && one_hot && !halt_q;
    end

    // Hold the registers and the skip and halt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            ext_q  <= 1'b0;
            skip_q <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            skip_q <= fire && take;
            if (fire) begin
                acc_q <= acc_nx;
                ext_q <= ext_nx;
            end
            if (fire && op_field[B_HALT]) begin
                halt_q <= 1'b1;
            end
        end
    end

    assign acc_out    = acc_q;
    assign ext_out    = ext_q;
    assign skip_pulse = skip_q;
    assign halted     = halt_q;
endmodule

// File: rtl/regop_checks.sv
// Module: regop_checks
// Property checks on the unit's ports, attached to every instance by bind.
module regop_checks #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_en,
    input logic [11:0]       op_field,
    input logic [DATA_W-1:0] acc_out,
    input logic              ext_out,
    input logic              skip_pulse,
    input logic              halted
);
    logic live;
    // Marks a strobe that the unit must act on.
    always_comb live = exec_en && !halted && ($countones(op_field) == 1);

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(acc_out) && $stable(ext_out) && !skip_pulse));

    a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_en && ($countones(op_field) == 1)) |=>
            ($stable(acc_out) && $stable(ext_out) && !skip_pulse));

    a_r4_rotate_right: assert property (@(posedge clk) disable iff (!rst_n)
        (live && op_field == 12'h080) |=>
            ({acc_out, ext_out} == {$past(ext_out), $past(acc_out)}));

    a_r5_rotate_left: assert property (@(posedge clk) disable iff (!rst_n)
        (live && op_field == 12'h040) |=>
            ({ext_out, acc_out} == {$past(acc_out), $past(ext_out)}));

    a_r6_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (live && op_field == 12'h020) |=>
            (acc_out == $past(acc_out) + 1'b1 && $stable(ext_out)));

    a_r7_skip_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(skip_pulse) |-> $past(live && (op_field & 12'h01E) != 12'h000));

    a_r10_skip_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_pulse && !live) |=> !skip_pulse);
endmodule

bind acc_regop_unit regop_checks #(.DATA_W(DATA_W)) i_regop_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_en    (exec_en),
    .op_field   (op_field),
    .acc_out    (acc_out),
    .ext_out    (ext_out),
    .skip_pulse (skip_pulse),
    .halted     (halted)
);

// File: tb/test_acc_regop_unit.sv
// Bench: directed scenarios, one task each, checked at the ports at negedge.
module test_acc_regop_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic [11:0] op_field = '0;
    logic [15:0] acc_out;
    logic        ext_out;
    logic        skip_pulse;
    logic        halted;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    acc_regop_unit i_acc_regop_unit (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_field(op_field),
        .acc_out(acc_out), .ext_out(ext_out), .skip_pulse(skip_pulse), .halted(halted)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One strobe; on return the results of that strobe are visible.
    task automatic issue(input logic [11:0] f);
        @(negedge clk);
        exec_en  = 1'b1;
        op_field = f;
        @(negedge clk);
        exec_en  = 1'b0;
        op_field = '0;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Builds a value by shifting bits in from E with left rotates.
    task automatic load(input logic [15:0] v, input logic e);
        issue(12'h800);
        for (int i = 15; i >= 0; i--) begin
            issue(12'h400);
            if (v[i]) issue(12'h100);
            issue(12'h040);
        end
        issue(12'h400);
        if (e) issue(12'h100);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 acc", acc_out, 0);
        check("R1 e", ext_out, 0);
        check("R1 skip", skip_pulse, 0);
        check("R1 halted", halted, 0);
    endtask

    task automatic t_clear();
        load(16'hA5A5, 1'b1);
        check("R2 load", acc_out, 16'hA5A5);
        issue(12'h800);
        check("R2 clear acc", acc_out, 0);
        check("R2 clear acc keeps e", ext_out, 1);
        load(16'h3C3C, 1'b1);
        issue(12'h400);
        check("R2 clear e", ext_out, 0);
        check("R2 clear e keeps acc", acc_out, 16'h3C3C);
    endtask

    task automatic t_complement();
        load(16'h1234, 1'b0);
        issue(12'h200);
        check("R3 cpl acc", acc_out, 16'hEDCB);
        check("R3 cpl acc keeps e", ext_out, 0);
        issue(12'h100);
        check("R3 cpl e", ext_out, 1);
        check("R3 cpl e keeps acc", acc_out, 16'hEDCB);
    endtask

    task automatic t_rotate();
        load(16'h8001, 1'b0);
        issue(12'h080);
        check("R4 ror acc", acc_out, 16'h4000);
        check("R4 ror e", ext_out, 1);
        issue(12'h080);
        check("R4 ror acc 2", acc_out, 16'hA000);
        check("R4 ror e 2", ext_out, 0);
        load(16'h8001, 1'b1);
        issue(12'h040);
        check("R5 rol acc", acc_out, 16'h0003);
        check("R5 rol e", ext_out, 1);
        load(16'h4000, 1'b0);
        issue(12'h040);
        check("R5 rol acc 2", acc_out, 16'h8000);
        check("R5 rol e 2", ext_out, 0);
    endtask

    task automatic t_increment();
        load(16'hFFFF, 1'b0);
        issue(12'h020);
        check("R6 wrap", acc_out, 16'h0000);
        check("R6 e kept 0", ext_out, 0);
        load(16'h7FFF, 1'b1);
        issue(12'h020);
        check("R6 carry to sign", acc_out, 16'h8000);
        check("R6 e kept 1", ext_out, 1);
    endtask

    task automatic skip_case(input logic [11:0] f, input logic exp, input string tag);
        logic [15:0] a0;
        logic        e0;
        a0 = acc_out;
        e0 = ext_out;
        issue(f);
        check({"R7 skip ", tag}, skip_pulse, exp);
        check({"R7 acc kept ", tag}, acc_out, a0);
        check({"R7 e kept ", tag}, ext_out, e0);
        idle_cycle();
        check({"R10 skip low ", tag}, skip_pulse, 0);
    endtask

    task automatic t_skip();
        load(16'h0000, 1'b0);
        skip_case(12'h010, 1, "pos@0");
        skip_case(12'h008, 0, "neg@0");
        skip_case(12'h004, 1, "zero@0");
        skip_case(12'h002, 1, "ez e0");
        load(16'h8000, 1'b1);
        skip_case(12'h010, 0, "pos@8000");
        skip_case(12'h008, 1, "neg@8000");
        skip_case(12'h004, 0, "zero@8000");
        skip_case(12'h002, 0, "ez e1");
        load(16'h0001, 1'b0);
        skip_case(12'h010, 1, "pos@1");
        skip_case(12'h004, 0, "zero@1");
    endtask

    task automatic t_ignored();
        load(16'h5A5A, 1'b1);
        issue(12'h000);
        check("R9 empty field acc", acc_out, 16'h5A5A);
        issue(12'h804);
        check("R9 two bits acc", acc_out, 16'h5A5A);
        check("R9 two bits skip", skip_pulse, 0);
        issue(12'h500);
        check("R9 two bits e", ext_out, 1);
        @(negedge clk);
        op_field = 12'h800;
        @(negedge clk);
        op_field = '0;
        check("R9 no strobe acc", acc_out, 16'h5A5A);
    endtask

    task automatic t_halt();
        load(16'h0F0F, 1'b0);
        issue(12'h001);
        check("R8 halted set", halted, 1);
        check("R8 halt keeps acc", acc_out, 16'h0F0F);
        issue(12'h200);
        check("R8 blocked cpl", acc_out, 16'h0F0F);
        issue(12'h100);
        check("R8 blocked cme", ext_out, 0);
        issue(12'h002);
        check("R8 blocked skip", skip_pulse, 0);
        check("R8 still halted", halted, 1);
        do_reset();
        check("R1 reset clears halt", halted, 0);
        check("R1 reset clears acc", acc_out, 0);
    endtask

    initial begin
        t_reset();
        t_clear();
        t_complement();
        t_rotate();
        t_increment();
        t_skip();
        t_ignored();
        t_halt();
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule